// File: doc/BRIEF.md
# Pipelined Pairwise-Exchange Permutation Network

This block reorders a vector of word lanes into any permutation of those lanes. It is a chain of registered stages, one fewer than the number of lanes. Each stage owns one anchor lane, the lane whose index equals the stage number, and a small select code. The code either leaves every lane where it is or swaps the anchor lane with one lane of higher index. Because stage s can move any remaining word into lane s, the stages together reach every ordering of the lanes.

A vector enters together with the select codes for all stages and a valid bit. Each stage registers the lanes, the valid bit and the codes still needed downstream, so every vector carries its own controls. The permuted vector appears after a fixed latency, and a new vector may enter on every clock. The codes for a wanted ordering are computed outside the block.

Top module: `pairx_perm_net`

## Requirements
- R1: A stage whose code is 0 passes every lane through unchanged.
- R2: Stage s (s = 0 to LANES-2) takes its code from in_sel bits [3s+2:3s]. A code k with 1 <= k <= LANES-1-s swaps lane s with lane s+k and leaves every other lane untouched. Lane n of a vector occupies data bits [8n+7:8n].
- R3: A code larger than LANES-1-s at stage s behaves as code 0. With 8 lanes, stage 0 has no such code and stage 6 accepts only code 1.
- R4: The stages act in order from stage 0 to stage 6, each on the result of the one before, so any of the 8! orderings can be produced by a suitable set of codes.
- R5: A vector presented with in_valid high appears on out_data exactly 7 clocks later, and vectors presented on consecutive clocks come out on consecutive clocks.
- R6: out_valid equals in_valid as sampled 7 clocks earlier, and it cannot be high before 7 clocks have passed since reset.
- R7: A synchronous active-high reset clears every valid bit, so out_valid is low in the clock after reset and any vector in flight is discarded.
- R8: Each stage performs at most one exchange, so the output lanes are always a rearrangement of the input lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks in_data and in_sel as a vector to permute |
| in_data | input | LANES*WIDTH (64) | Input lanes, lane 0 in the low bits |
| in_sel | input | (LANES-1)*3 (21) | Select codes, stage 0 in the low bits |
| out_valid | output | 1 | Marks out_data as a permuted vector |
| out_data | output | LANES*WIDTH (64) | Permuted lanes, lane 0 in the low bits |

## Verification
The assertions assume that in_valid, in_sel and in_data are known whenever they are sampled outside reset, and that reset is high at the first clock; the bench drives all inputs on the falling edge from time zero and holds reset for several clocks at the start. The lane-conservation and pass-through properties only look at cycles where a stage holds a valid word, so the undefined contents of unreset data registers never reach them. The stimulus sweeps every legal and illegal code at every stage, fully random codes, computed permutations, bubbles in the valid stream and a reset in the middle of traffic.

// File: rtl/pairx_pkg.sv
package pairx_pkg;

  // Lane that the anchor is exchanged with for a given code; the anchor
  // itself means no exchange (code 0 or code past the last lane).
  function automatic int unsigned partner_of(input int unsigned anchor,
                                             input int unsigned code,
                                             input int unsigned lanes);
    if (code != 0 && anchor + code < lanes) return anchor + code;
    return anchor;
  endfunction

endpackage

// File: rtl/pairx_decode.sv
module pairx_decode #(
  parameter int LANES  = 8,
  parameter int SELW   = 3,
  parameter int ANCHOR = 0
) (
  input  logic [SELW-1:0]  code,
  output logic [LANES-1:0] hit_mask
);
  import pairx_pkg::*;

  always_comb begin
    int unsigned p;
    hit_mask = '0;
    p = partner_of(ANCHOR, int'(code), LANES);
    if (p != ANCHOR) hit_mask[p] = 1'b1;
  end

endmodule

// File: rtl/pairx_stage.sv
module pairx_stage #(
  parameter int LANES  = 8,
  parameter int WIDTH  = 8,
  parameter int SELW   = 3,
  parameter int SELALL = 21,
  parameter int ANCHOR = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   v_in,
  input  logic [LANES*WIDTH-1:0] lanes_in,
  input  logic [SELALL-1:0]      sel_in,
  output logic                   v_q,
  output logic [LANES*WIDTH-1:0] lanes_q,
  output logic [SELALL-1:0]      sel_q
);

  localparam int BUSW = LANES * WIDTH;

  function automatic logic [WIDTH-1:0] fold(input logic [BUSW-1:0] bus);
    logic [WIDTH-1:0] acc;
    acc = '0;
    for (int l = 0; l < LANES; l++) acc ^= bus[l*WIDTH +: WIDTH];
    return acc;
  endfunction

  logic [SELW-1:0]  code_in;
  logic [LANES-1:0] hit_mask;
  logic             swap_en;
  logic [WIDTH-1:0] partner_val;
  logic [WIDTH-1:0] anchor_val;
  logic [BUSW-1:0]  lanes_nx;
  logic [WIDTH-1:0] fold_in, fold_q;

  assign code_in    = sel_in[SELW-1:0];
  assign swap_en    = |hit_mask;
  assign anchor_val = lanes_in[ANCHOR*WIDTH +: WIDTH];

  pairx_decode #(.LANES(LANES), .SELW(SELW), .ANCHOR(ANCHOR)) u_dec (
    .code     (code_in),
    .hit_mask (hit_mask)
  );

  always_comb begin
    partner_val = '0;
    for (int l = 0; l < LANES; l++)
      partner_val |= {WIDTH{hit_mask[l]}} & lanes_in[l*WIDTH +: WIDTH];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == ANCHOR) begin : g_anchor
      assign lanes_nx[l*WIDTH +: WIDTH] = swap_en ? partner_val : anchor_val;
    end else begin : g_other
      assign lanes_nx[l*WIDTH +: WIDTH] =
        hit_mask[l] ? anchor_val : lanes_in[l*WIDTH +: WIDTH];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= v_in;
    lanes_q <= lanes_nx;
    sel_q   <= sel_in >> SELW;
  end

  assign fold_in = fold(lanes_in);
  assign fold_q  = fold(lanes_q);

  // R7: reset empties this stage
  a_r7_reset_clears: assert property (@(posedge clk) rst |=> !v_q);

  // R8: the decoded exchange selects at most one partner
  a_r8_single_exchange: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_mask));

  // R3: the anchor is never exchanged with itself or a lower lane
  a_r3_upward_only: assert property (@(posedge clk) disable iff (rst)
    (hit_mask & LANES'((1 << (ANCHOR + 1)) - 1)) == '0);

  // R8: a valid word leaves the stage with the same lane contents rearranged
  a_r8_lanes_conserved: assert property (@(posedge clk) disable iff (rst)
    v_q |-> fold_q == $past(fold_in));

  // R1: code 0 gives the lanes back untouched
  a_r1_pass_through: assert property (@(posedge clk) disable iff (rst)
    (v_q && $past(code_in) == '0) |-> lanes_q == $past(lanes_in));

endmodule

// File: rtl/pairx_perm_net.sv
module pairx_perm_net #(
  parameter int LANES = 8,
  parameter int WIDTH = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  in_valid,
  input  logic [LANES*WIDTH-1:0]                in_data,
  input  logic [(LANES-1)*$clog2(LANES)-1:0]    in_sel,
  output logic                                  out_valid,
  output logic [LANES*WIDTH-1:0]                out_data
);

  localparam int STAGES = LANES - 1;
  localparam int SELW   = $clog2(LANES);
  localparam int SELALL = STAGES * SELW;
  localparam int BUSW   = LANES * WIDTH;
  localparam int CW     = $clog2(STAGES + 1);

  logic              v_bus   [0:STAGES];
  logic [BUSW-1:0]   lane_bus[0:STAGES];
  logic [SELALL-1:0] sel_bus [0:STAGES];

  assign v_bus[0]    = in_valid;
  assign lane_bus[0] = in_data;
  assign sel_bus[0]  = in_sel;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    pairx_stage #(
      .LANES(LANES), .WIDTH(WIDTH), .SELW(SELW),
      .SELALL(SELALL), .ANCHOR(s)
    ) u_stage (
      .clk      (clk),
      .rst      (rst),
      .v_in     (v_bus[s]),
      .lanes_in (lane_bus[s]),
      .sel_in   (sel_bus[s]),
      .v_q      (v_bus[s+1]),
      .lanes_q  (lane_bus[s+1]),
      .sel_q    (sel_bus[s+1])
    );
  end

  assign out_valid = v_bus[STAGES];
  assign out_data  = lane_bus[STAGES];

  // Cycles since reset, saturating at the pipeline depth (assertion aid).
  logic [CW-1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)                       warm_q <= '0;
    else if (warm_q < CW'(STAGES)) warm_q <= warm_q + 1'b1;
  end

  // R6: nothing can reach the output before the pipeline has filled
  a_r6_no_early_valid: assert property (@(posedge clk) disable iff (rst)
    (warm_q < CW'(STAGES)) |-> !out_valid);

endmodule

// File: tb/pairx_perm_net_bench.sv
`timescale 1ns/1ps
module pairx_perm_net_bench;
  localparam int LANES = 8, WIDTH = 8, STAGES = 7, SELW = 3;
  localparam int BUSW = LANES * WIDTH, SELALL = STAGES * SELW;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [BUSW-1:0]   in_data = '0;
  logic [SELALL-1:0] in_sel  = '0;
  logic              out_valid;
  logic [BUSW-1:0]   out_data;
  string cur_tag = "R1";

  int checks = 0, errors = 0, cycles = 0;
  bit primed = 0, done = 0;

  always #2.5 clk = ~clk;

  pairx_perm_net #(.LANES(LANES), .WIDTH(WIDTH)) u_pairx_perm_net (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sel(in_sel), .out_valid(out_valid), .out_data(out_data));

  // Behavioural model: walk the stages in order on an integer lane array.
  function automatic logic [BUSW-1:0] model(input logic [BUSW-1:0] d,
                                            input logic [SELALL-1:0] s);
    int lane[LANES];
    logic [BUSW-1:0] r;
    for (int n = 0; n < LANES; n++) lane[n] = int'(d[n*WIDTH +: WIDTH]);
    for (int st = 0; st < STAGES; st++) begin
      int k = int'(s[st*SELW +: SELW]);
      if (k >= 1 && k <= LANES - 1 - st) begin
        int t = lane[st];
        lane[st] = lane[st+k];
        lane[st+k] = t;
      end
    end
    for (int n = 0; n < LANES; n++) r[n*WIDTH +: WIDTH] = WIDTH'(lane[n]);
    return r;
  endfunction

  // Codes that place input lane perm[p] at output lane p (selection order).
  function automatic logic [SELALL-1:0] codes_for(input int perm[LANES]);
    int idx[LANES];
    logic [SELALL-1:0] c = '0;
    for (int n = 0; n < LANES; n++) idx[n] = n;
    for (int st = 0; st < STAGES; st++) begin
      int j = st;
      for (int n = st; n < LANES; n++) if (idx[n] == perm[st]) j = n;
      c[st*SELW +: SELW] = SELW'(j - st);
      begin int t = idx[st]; idx[st] = idx[j]; idx[j] = t; end
    end
    return c;
  endfunction

  // Expected pipeline, one slot per clock of latency.
  logic            exp_v[STAGES];
  logic [BUSW-1:0] exp_d[STAGES];
  string           exp_t[STAGES];

  always @(posedge clk) begin
    cycles++;
    primed = 1;
    if (rst) begin
      for (int n = 0; n < STAGES; n++) begin exp_v[n] = 0; exp_t[n] = "R7"; end
    end else begin
      for (int n = STAGES - 1; n > 0; n--) begin
        exp_v[n] = exp_v[n-1]; exp_d[n] = exp_d[n-1]; exp_t[n] = exp_t[n-1];
      end
      exp_v[0] = in_valid;
      exp_d[0] = model(in_data, in_sel);
      exp_t[0] = cur_tag;
    end
  end

  always @(negedge clk) begin
    if (primed && !done) begin
      checks++;
      if (out_valid !== exp_v[STAGES-1]) begin
        errors++;
        $display("FAIL R6 (%s) out_valid: actual %b expected %b at cycle %0d",
                 exp_t[STAGES-1], out_valid, exp_v[STAGES-1], cycles);
      end
      if (exp_v[STAGES-1]) begin
        checks++;
        if (out_data !== exp_d[STAGES-1]) begin
          errors++;
          $display("FAIL %s R5 out_data: actual %h expected %h at cycle %0d",
                   exp_t[STAGES-1], out_data, exp_d[STAGES-1], cycles);
        end
      end
    end
  end

  task automatic send(input logic [BUSW-1:0] d, input logic [SELALL-1:0] s,
                      input string t);
    in_valid = 1'b1; in_data = d; in_sel = s; cur_tag = t;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0; in_data = {$urandom, $urandom}; in_sel = SELALL'($urandom);
      @(negedge clk);
    end
  endtask

  function automatic logic [BUSW-1:0] rnd_data();
    return {$urandom, $urandom};
  endfunction

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    int perm[LANES];
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;

    // R1: all-pass codes
    for (int i = 0; i < 3; i++) send(rnd_data(), '0, "R1");
    // R2: every legal code at every stage, back to back (R5 throughput)
    for (int st = 0; st < STAGES; st++)
      for (int k = 1; k <= LANES - 1 - st; k++) begin
        logic [SELALL-1:0] s = '0;
        s[st*SELW +: SELW] = SELW'(k);
        send(64'h0706050403020100 ^ rnd_data() & 64'h0, s, "R2");
        send(rnd_data(), s, "R2");
      end
    // R3: codes past the last lane behave as pass-through
    for (int st = 1; st < STAGES; st++)
      for (int k = LANES - st; k < LANES; k++) begin
        logic [SELALL-1:0] s = '0;
        s[st*SELW +: SELW] = SELW'(k);
        send(rnd_data(), s, "R3");
      end
    // R4: computed permutations: reversal, rotation, random orderings
    for (int p = 0; p < LANES; p++) perm[p] = LANES - 1 - p;
    send(64'h0706050403020100, codes_for(perm), "R4");
    for (int p = 0; p < LANES; p++) perm[p] = (p + 3) % LANES;
    send(64'h0706050403020100, codes_for(perm), "R4");
    for (int r = 0; r < 20; r++) begin
      for (int p = 0; p < LANES; p++) perm[p] = p;
      for (int p = LANES - 1; p > 0; p--) begin
        int q = $urandom_range(p, 0);
        int t = perm[p]; perm[p] = perm[q]; perm[q] = t;
      end
      send(rnd_data(), codes_for(perm), "R4");
    end
    // R8: fully random codes including illegal ones
    for (int r = 0; r < 30; r++) send(rnd_data(), SELALL'($urandom), "R8");
    // R6: bubbles in the valid stream
    for (int r = 0; r < 12; r++) begin
      send(rnd_data(), SELALL'($urandom), "R6");
      idle(r % 3);
    end
    idle(STAGES + 2);
    // R7: reset in the middle of traffic discards vectors in flight
    for (int r = 0; r < 4; r++) send(rnd_data(), SELALL'($urandom), "R7");
    rst = 1'b1;
    idle(1);
    rst = 1'b0;
    idle(STAGES + 3);
    send(rnd_data(), SELALL'($urandom), "R5");
    idle(STAGES + 3);
    finish_run();
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule